// File: doc/BRIEF.md
# Multi-width SIMD carry-less multiplier

This block multiplies two 128-bit operand vectors lane by lane in GF(2)[x]. Each lane's product uses XOR in place of addition, so no carries arise. A run-time element-width select cuts the datapath into 16 lanes of 8 bits, 8 lanes of 16 bits, 4 lanes of 32 bits or 2 lanes of 64 bits. A half select picks, for every lane, either the lower or the upper half of its double-width product. That half is returned in the lane's own slot of the 128-bit result.

The operands are not split into separate multipliers. Each 64-bit chunk of the datapath feeds one partial-product array. At run time that array is masked so that only bit pairs from the same lane contribute. A lane's double-width product then lands in its own field of the array output, and fields of different lanes never overlap. A request is taken on a valid/ready handshake. The result comes out one cycle later with its own valid, and it is held while the consumer stalls. The latency is the same for every operand value.

The chunk width is a parameter. Built with 32-bit chunks, the unit offers the 8, 16 and 32-bit element modes on their own and treats the 64-bit code as unsupported.

Top module: `simd_clmul_unit`

## Requirements
- R1: The width code on `ew_sel_i` selects the element width SEW: 0 selects 8, 1 selects 16, 2 selects 32 and 3 selects 64. The datapath then holds 128/SEW lanes. Lane L occupies bits L*SEW to L*SEW+SEW-1 of each operand and of the result.
- R2: With `hi_sel_i`=0, each lane of the result holds bits SEW-1..0 of the carry-less product of that lane's two operands.
- R3: With `hi_sel_i`=1, each lane holds bits 2*SEW-1..SEW of that lane's carry-less product. The top bit of each lane is therefore always 0.
- R4: A lane's result depends only on that lane's operand bits. Changing the operands of one lane leaves every other lane of the result unchanged.
- R5: Width codes 4 to 7 are unsupported, and so is code 3 when the chunk width is 32. An unsupported code gives `res_err_o`=1 and an all-zero result. A supported code gives `res_err_o`=0.
- R6: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. At the next edge `res_valid_o` becomes 1 and the result is present.
- R7: While `res_valid_o`=1 and `res_ready_i`=0, `req_ready_o` is 0, and the result, the error flag and the valid flag hold their values. When `res_valid_o`=0, `req_ready_o` is 1.
- R8: After a synchronous active-low reset, `res_valid_o`=0, `res_o`=0, `res_err_o`=0 and `req_ready_o`=1.
- R9: The latency is one cycle for every operand value, including all-zero operands. No operand value shortens or lengthens an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| opa_i | input | 128 | First operand vector |
| opb_i | input | 128 | Second operand vector |
| ew_sel_i | input | 3 | Element width code |
| hi_sel_i | input | 1 | 1 returns the upper product half, 0 the lower |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 128 | Result vector |
| res_err_o | output | 1 | Unsupported width code was requested |

## Verification
The bench builds the unit with its defaults: a 128-bit datapath made of two 64-bit chunks. With these values all four element widths can be selected, and the 64-bit code is a legal value. The error path is therefore reached only through codes 4 to 7. Every lane at every width and in both halves is compared against a bit-serial shift-and-XOR model. Because the two chunks meet at bit 64, the 64-bit lanes also test the boundary between chunks.

// File: rtl/clmul_pkg.sv
// Package: constants and helpers shared by the carry-less multiplier.
// Assumes element widths are powers of two from 8 upward.
package clmul_pkg;
    localparam int EW_SEL_W = 3;   // width of the element-width code
    localparam int MIN_LG   = 3;   // log2 of the smallest element width (8)

    // Returns 1 when the width code is legal for a chunk of chunk_w bits.
    function automatic logic ew_code_ok(input logic [EW_SEL_W-1:0] code, input int chunk_w);
        return (int'(code) + MIN_LG) <= $clog2(chunk_w);
    endfunction
endpackage

// File: rtl/clmul_masked_core.sv
// Module: carry-less partial-product array for one chunk, masked by lane.
// Only bit pairs (i, j) of the same lane contribute to product bit i+j.
// Lane L of width S places its double product at field 2*L*S, so the fields
// of different lanes never overlap. Assumes lg_i is at most log2(CW).
module clmul_masked_core #(
    parameter int CW   = 64,
    parameter int LG_W = 3
) (
    input  logic [CW-1:0]   a_i,
    input  logic [CW-1:0]   b_i,
    input  logic [LG_W-1:0] lg_i,
    output logic [2*CW-1:0] prod_o
);
    // XOR-accumulate the masked partial products of the whole chunk.
    always_comb begin
        prod_o = '0;
        for (int i = 0; i < CW; i++) begin
            for (int j = 0; j < CW; j++) begin
                if ((i >> lg_i) == (j >> lg_i)) begin
                    prod_o[i+j] = prod_o[i+j] ^ (a_i[i] & b_i[j]);
                end
            end
        end
    end
endmodule

// File: rtl/clmul_lane_pick.sv
// Module: gathers the lower or upper half of each lane's product field.
// Assumes the field layout of clmul_masked_core (lane L at bit 2*L*S).
module clmul_lane_pick #(
    parameter int CW   = 64,
    parameter int LG_W = 3
) (
    input  logic [2*CW-1:0] prod_i,
    input  logic [LG_W-1:0] lg_i,
    input  logic            hi_i,
    output logic [CW-1:0]   res_o
);
    // Route each result bit from its lane's chosen half.
    always_comb begin
        res_o = '0;
        for (int r = 0; r < CW; r++) begin
            int s;
            int lane;
            int src;
            s    = 1 << lg_i;
            lane = r >> lg_i;
            src  = 2 * lane * s + (r - lane * s) + (hi_i ? s : 0);
            if (src < 2 * CW) res_o[r] = prod_i[src];
        end
    end

    // R3: the top bit of each lane's upper half carries no partial product.
    always_comb begin
        if (hi_i && int'(lg_i) <= $clog2(CW)) begin
            for (int l = 0; l < CW; l += (1 << lg_i)) begin
                a_r3_hi_msb_zero: assert (res_o[l + (1 << lg_i) - 1] == 1'b0);
            end
        end
    end
endmodule

// File: rtl/simd_clmul_unit.sv
// Module: 128-bit SIMD carry-less multiplier with selectable element width
// and product half. It has one register stage. The operands are split into
// CHUNK_W chunks, each served by one masked array. Assumes that DATA_W is a
// multiple of CHUNK_W and that CHUNK_W is a power of two from 8 up to 64.
module simd_clmul_unit
    import clmul_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int CHUNK_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    input  logic [EW_SEL_W-1:0] ew_sel_i,
    input  logic                hi_sel_i,
    output logic                res_valid_o,
    input  logic                res_ready_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                res_err_o
);
    localparam int NCHUNK = DATA_W / CHUNK_W;
    localparam int LG_W   = $clog2($clog2(CHUNK_W) + 1);

    logic              code_ok;
    logic [LG_W-1:0]   lg;
    logic [DATA_W-1:0] lanes;
    logic              fire;

    // Decode the width code into log2(SEW) and a legality flag.
    always_comb begin
        code_ok = ew_code_ok(ew_sel_i, CHUNK_W);
        lg      = LG_W'(ew_sel_i) + LG_W'(MIN_LG);
    end

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        logic [2*CHUNK_W-1:0] prod;

        clmul_masked_core #(.CW(CHUNK_W), .LG_W(LG_W)) u_core (
            .a_i   (opa_i[c*CHUNK_W +: CHUNK_W]),
            .b_i   (opb_i[c*CHUNK_W +: CHUNK_W]),
            .lg_i  (lg),
            .prod_o(prod)
        );

        clmul_lane_pick #(.CW(CHUNK_W), .LG_W(LG_W)) u_pick (
            .prod_i(prod),
            .lg_i  (lg),
            .hi_i  (hi_sel_i),
            .res_o (lanes[c*CHUNK_W +: CHUNK_W])
        );
    end

    // Accept when the output slot is empty or is being drained.
    always_comb begin
        req_ready_o = !res_valid_o || res_ready_i;
        fire        = req_valid_i && req_ready_o;
    end

    // Output register: load on accept, clear valid on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_o       <= '0;
            res_err_o   <= 1'b0;
        end else if (fire) begin
            res_valid_o <= 1'b1;
            res_o       <= code_ok ? lanes : '0;
            res_err_o   <= !code_ok;
        end else if (res_ready_i) begin
            res_valid_o <= 1'b0;
        end
    end

    // R6: an accepted request gives a valid result one edge later.
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> res_valid_o);

    // R7: a stalled result holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_o) && $stable(res_err_o)));

    // R7: an empty output slot always accepts.
    a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> req_ready_o);

    // R5: a flagged result is all zero.
    a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_err_o) |-> (res_o == '0));
endmodule

// File: tb/sim_simd_clmul_unit.sv
module sim_simd_clmul_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid_i;
    logic         req_ready_o;
    logic [127:0] opa_i;
    logic [127:0] opb_i;
    logic [2:0]   ew_sel_i;
    logic         hi_sel_i;
    logic         res_valid_o;
    logic         res_ready_i;
    logic [127:0] res_o;
    logic         res_err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_clmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .opa_i(opa_i), .opb_i(opb_i), .ew_sel_i(ew_sel_i), .hi_sel_i(hi_sel_i),
        .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_o(res_o),
        .res_err_o(res_err_o)
    );

    // Bit-serial shift-and-XOR model, computed lane by lane.
    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input int lg, input bit hi);
        int s = 1 << lg;
        logic [127:0] mask = (128'd1 << s) - 128'd1;
        logic [127:0] res = '0;
        for (int l = 0; l < 128 / s; l++) begin
            logic [127:0] al = (a >> (l * s)) & mask;
            logic [127:0] acc = '0;
            for (int i = 0; i < s; i++) begin
                if (b[l * s + i]) acc = acc ^ (al << i);
            end
            if (hi) acc = acc >> s;
            res = res | ((acc & mask) << (l * s));
        end
        return res;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; sample after the next rising edge.
    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input logic [2:0] code, input bit hi);
        @(negedge clk);
        opa_i = a; opb_i = b; ew_sel_i = code; hi_sel_i = hi; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid_i = 1'b0; res_ready_i = 1'b1;
        opa_i = '0; opb_i = '0; ew_sel_i = '0; hi_sel_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 valid", 128'(res_valid_o), 128'd0);
        check("R8 result", res_o, '0);
        check("R8 err", 128'(res_err_o), 128'd0);
        check("R8 ready", 128'(req_ready_o), 128'd1);
    endtask

    // R1 R2 R3: random operands at every width and both halves.
    task automatic t_random_all();
        for (int code = 0; code < 4; code++) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int n = 0; n < 6; n++) begin
                    logic [127:0] a = rnd128();
                    logic [127:0] b = rnd128();
                    issue(a, b, 3'(code), hi[0]);
                    check(hi ? "R3 high half" : "R2 low half", res_o, model(a, b, code + 3, hi[0]));
                    check("R6 valid after one cycle", 128'(res_valid_o), 128'd1);
                    check("R5 no error on legal code", 128'(res_err_o), 128'd0);
                end
            end
        end
    endtask

    // R3: all-ones operands, high half, top bit of every lane must be zero.
    task automatic t_hi_msb();
        for (int code = 0; code < 4; code++) begin
            int s = 8 << code;
            logic [127:0] topmask = '0;
            for (int l = 0; l < 128 / s; l++) topmask[l * s + s - 1] = 1'b1;
            issue('1, '1, 3'(code), 1'b1);
            check("R3 lane msb zero", res_o & topmask, '0);
            check("R3 all-ones high", res_o, model('1, '1, code + 3, 1'b1));
        end
    endtask

    // R4: change one lane's operands; other lanes must not move.
    task automatic t_cross_lane();
        for (int code = 0; code < 4; code++) begin
            int s = 8 << code;
            logic [127:0] a = rnd128();
            logic [127:0] b = rnd128();
            logic [127:0] first;
            logic [127:0] lmask = ((128'd1 << s) - 128'd1) << s;  // lane 1
            issue(a, b, 3'(code), 1'b1);
            first = res_o;
            issue(a ^ lmask, b ^ (lmask & rnd128()), 3'(code), 1'b1);
            check("R4 other lanes unchanged", res_o & ~lmask, first & ~lmask);
        end
    endtask

    // R5: unsupported codes flag an error and give zero.
    task automatic t_invalid();
        for (int code = 4; code < 8; code++) begin
            issue('1, '1, 3'(code), code[0]);
            check("R5 err flag", 128'(res_err_o), 128'd1);
            check("R5 zero result", res_o, '0);
        end
    endtask

    // R7: back-pressure holds the result and blocks new input.
    task automatic t_backpressure();
        logic [127:0] a1 = rnd128(), b1 = rnd128(), a2 = rnd128(), b2 = rnd128();
        @(negedge clk);
        res_ready_i = 1'b0;
        opa_i = a1; opb_i = b1; ew_sel_i = 3'd2; hi_sel_i = 1'b0; req_valid_i = 1'b1;
        @(negedge clk);
        check("R7 first result", res_o, model(a1, b1, 5, 1'b0));
        check("R7 ready low on stall", 128'(req_ready_o), 128'd0);
        opa_i = a2; opb_i = b2; ew_sel_i = 3'd1; hi_sel_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 held during stall", res_o, model(a1, b1, 5, 1'b0));
        check("R7 valid held", 128'(res_valid_o), 128'd1);
        res_ready_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        check("R7 next result after drain", res_o, model(a2, b2, 4, 1'b1));
        @(negedge clk);
        check("R7 valid drops when drained", 128'(res_valid_o), 128'd0);
    endtask

    // R9: all-zero operands take the same single cycle.
    task automatic t_zero_latency();
        @(negedge clk);
        opa_i = '0; opb_i = '0; ew_sel_i = 3'd3; hi_sel_i = 1'b0; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        check("R9 zero operands valid after one cycle", 128'(res_valid_o), 128'd1);
        check("R9 zero product", res_o, '0);
    endtask

    initial begin
        t_reset();
        t_random_all();
        t_hi_msb();
        t_cross_lane();
        t_invalid();
        t_backpressure();
        t_zero_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule